// File: doc/BRIEF.md
# Quadrature Direction Decoder

This block follows a rotary sensor that produces two square-wave phases, A and B, a quarter period apart. Both phases are brought into the system clock domain through a synchronizer chain. The block then keeps a four-bit record of motion. The upper two bits hold the pair that was accepted before the latest one, and the lower two bits hold the latest accepted pair.

The record moves forward only on a clock edge where the synchronized pair differs from the last accepted pair. On each such edge the block:
- emits a one-cycle step pulse;
- recomputes the direction flag from the record;
- raises an error pulse if both phases changed at once.

A signed position counter follows the step pulses. It counts up or down according to the direction flag and ignores the illegal double-phase jumps. All state changes on the rising clock edge, and the reset is synchronous.

Top module: `quad_track`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `hist_o`=0, `pos_o`=0, `step_o`=0, `err_o`=0 and `dir_o`=1.
- R2: With the default of two synchronizer stages, a change on `a_i`/`b_i` first appears in `hist_o` and `step_o` after the third rising edge that follows it.
- R3: A synchronized pair equal to the last accepted pair (`hist_o[1:0]`) changes neither `hist_o` nor `pos_o`, and produces no step pulse.
- R4: On an update, the old `hist_o[1:0]` moves to `hist_o[3:2]` and the new pair goes to `hist_o[1:0]`. Bit 1 carries A and bit 0 carries B.
- R5: `dir_o` is 1 exactly when `hist_o[3]` (previous A) equals `hist_o[0]` (latest B). The sequence AB = 00,10,11,01 therefore gives 1 (up), and 00,01,11,10 gives 0 (down).
- R6: `step_o` is high for exactly the cycle that follows each update of `hist_o`, and is low otherwise.
- R7: One edge after a step without error, `pos_o` (two's complement, POS_W bits, wrapping) rises by one if `dir_o` was 1 and falls by one if it was 0. With no step, `pos_o` holds.
- R8: When both A and B change in one accepted update, `err_o` is high alongside `step_o` for that cycle, and `pos_o` stays unchanged.
- R9: Asserting `rst` mid-operation returns every output to its R1 value, and counting resumes from zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 1 | Phase A from sensor, asynchronous |
| b_i | input | 1 | Phase B from sensor, asynchronous |
| hist_o | output | 4 | Motion record {prevA, prevB, curA, curB} |
| dir_o | output | 1 | Direction flag, 1 = up |
| step_o | output | 1 | One-cycle pulse per accepted change |
| err_o | output | 1 | One-cycle pulse on a double-phase jump |
| pos_o | output | POS_W | Signed position count |

## Verification
The hardest case to reach from the ports is the illegal jump, where both phases must change within the same sampled cycle. A real sensor cannot produce this jump while the decoder is tracking it. The stimulus gets there by writing both phase inputs at one falling edge, so both bits travel through the synchronizer together and arrive in the same accepted update. The stimulus also walks both rotation directions far enough that the count goes negative. Finally, it holds a steady pair to show that no update takes place, and it resets the block from a non-zero count.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int PAIR_W = 2;
  localparam int HIST_W = 2 * PAIR_W;
  typedef logic [PAIR_W-1:0] pair_t;   // {A, B}
  typedef logic [HIST_W-1:0] hist_t;   // {prevA, prevB, curA, curB}
endpackage

// File: rtl/qt_sync.sv
module qt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qt_hist.sv
module qt_hist
  import qt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pair_t pair_i,
  output hist_t hist_o,
  output logic  dir_o,
  output logic  step_o,
  output logic  err_o
);
  hist_t hist_q;
  logic  dir_q, step_q, err_q;
  pair_t last;
  logic  changed, both;

  assign last    = hist_q[PAIR_W-1:0];
  assign changed = (pair_i != last);
  assign both    = &(pair_i ^ last);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      dir_q  <= 1'b1;
      step_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      step_q <= changed;
      err_q  <= changed && both;
      if (changed) begin
        hist_q <= {last, pair_i};
        dir_q  <= (last[1] == pair_i[0]);
      end
    end
  end

  assign hist_o = hist_q;
  assign dir_o  = dir_q;
  assign step_o = step_q;
  assign err_o  = err_q;
endmodule

// File: rtl/qt_pos.sv
module qt_pos #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             err_i,
  input  logic             dir_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else if (step_i && !err_i) pos_q <= dir_i ? pos_q + ONE : pos_q - ONE;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/quad_track.sv
module quad_track
  import qt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_i,
  input  logic             b_i,
  output logic [3:0]       hist_o,
  output logic             dir_o,
  output logic             step_o,
  output logic             err_o,
  output logic [POS_W-1:0] pos_o
);
  pair_t pair_s;
  hist_t hist;
  logic  dir, step, err;

  qt_sync #(.STAGES(SYNC_STAGES), .WIDTH(PAIR_W)) u_sync (
    .clk(clk), .rst(rst), .d_i({a_i, b_i}), .q_o(pair_s)
  );

  qt_hist u_hist (
    .clk(clk), .rst(rst), .pair_i(pair_s),
    .hist_o(hist), .dir_o(dir), .step_o(step), .err_o(err)
  );

  qt_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .step_i(step), .err_i(err), .dir_i(dir), .pos_o(pos_o)
  );

  assign hist_o = hist;
  assign dir_o  = dir;
  assign step_o = step;
  assign err_o  = err;
endmodule

// File: rtl/quad_track_chk.sv
module quad_track_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       hist_o,
  input logic             dir_o,
  input logic             step_o,
  input logic             err_o,
  input logic [POS_W-1:0] pos_o
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (hist_o == 4'd0 && pos_o == '0 && !step_o && !err_o && dir_o));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step_o |-> $stable(hist_o));

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    step_o |-> (hist_o[3:2] == $past(hist_o[1:0]) && hist_o[1:0] != $past(hist_o[1:0])));

  p_dir_r5: assert property (@(posedge clk) disable iff (rst)
    dir_o == (hist_o[3] ~^ hist_o[0]));

  p_up_r7: assert property (@(posedge clk) disable iff (rst)
    (step_o && !err_o && dir_o) |=> pos_o == $past(pos_o) + POS_W'(1));

  p_down_r7: assert property (@(posedge clk) disable iff (rst)
    (step_o && !err_o && !dir_o) |=> pos_o == $past(pos_o) - POS_W'(1));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !step_o |=> $stable(pos_o));

  p_err_step_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (step_o && (hist_o[3:2] ^ hist_o[1:0]) == 2'b11));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> $stable(pos_o));
endmodule

bind quad_track quad_track_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .hist_o(hist_o), .dir_o(dir_o),
  .step_o(step_o), .err_o(err_o), .pos_o(pos_o)
);

// File: tb/quad_track_tb.sv
module quad_track_tb;
  localparam int POS_W = 16;

  typedef struct packed {
    logic [3:0]       hist;
    logic             dir;
    logic             err;
    logic [POS_W-1:0] pos;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_i = 1'b0, b_i = 1'b0;
  logic [3:0] hist_o;
  logic dir_o, step_o, err_o;
  logic [POS_W-1:0] pos_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [3:0]       m_hist = 4'd0;
  logic [POS_W-1:0] m_pos  = '0;

  always #4 clk = ~clk;   // 125 MHz

  quad_track #(.SYNC_STAGES(2), .POS_W(POS_W)) u_dut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .hist_o(hist_o),
    .dir_o(dir_o), .step_o(step_o), .err_o(err_o), .pos_o(pos_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: applies a pair and pushes the expected result when it is a change.
  task automatic drive(input logic a, input logic b);
    exp_t e;
    logic [1:0] np;
    @(negedge clk);
    a_i = a; b_i = b;
    np = {a, b};
    if (np != m_hist[1:0]) begin
      e.err  = (np[1] != m_hist[1]) && (np[0] != m_hist[0]);
      m_hist = {m_hist[1:0], np};
      e.hist = m_hist;
      e.dir  = (m_hist[3] == m_hist[0]);
      if (!e.err) m_pos = e.dir ? m_pos + 1'b1 : m_pos - 1'b1;
      e.pos  = m_pos;
      q.push_back(e);
    end
  endtask

  task automatic move(input logic a, input logic b);
    drive(a, b);
    repeat (6) @(negedge clk);
  endtask

  // Monitor: compares every step against the scoreboard.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && step_o) begin
        if (q.size() == 0) begin
          chk("R3 spurious step", 32'(step_o), 32'd0);
        end else begin
          e = q.pop_front();
          chk("R4 hist", 32'(hist_o), 32'(e.hist));
          chk("R5 dir", 32'(dir_o), 32'(e.dir));
          chk("R8 err", 32'(err_o), 32'(e.err));
          @(negedge clk);
          chk("R6 step width", 32'(step_o), 32'd0);
          chk(e.err ? "R8 pos held" : "R7 pos", 32'(pos_o), 32'(e.pos));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 hist", 32'(hist_o), 32'd0);
    chk("R1 pos", 32'(pos_o), 32'd0);
    chk("R1 step", 32'(step_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    chk("R1 dir", 32'(dir_o), 32'd1);

    // R5/R7 up: 00,10,11,01 twice
    repeat (2) begin
      move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    end
    chk("R7 up total", 32'(pos_o), 32'd8);
    // R5/R7 down: 00,01,11,10 three times -> -4
    repeat (3) begin
      move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    end
    chk("R7 negative", 32'(pos_o), 32'(16'hFFFC));

    // R8 illegal jumps
    move(1, 1);
    move(0, 0);
    move(1, 0);
    move(0, 1);
    chk("R8 pos after jumps", 32'(pos_o), 32'(m_pos));

    // R3 hold the same pair
    move(0, 1);
    repeat (10) @(negedge clk);
    chk("R3 hist held", 32'(hist_o), 32'(m_hist));
    chk("R3 pos held", 32'(pos_o), 32'(m_pos));

    // R2 latency: 01 -> 11
    drive(1, 1);
    @(negedge clk); chk("R2 edge1", 32'(step_o), 32'd0);
    @(negedge clk); chk("R2 edge2", 32'(step_o), 32'd0);
    @(negedge clk); chk("R2 edge3", 32'(step_o), 32'd1);
    repeat (6) @(negedge clk);

    // R9 reset mid-operation
    @(negedge clk);
    rst = 1'b1; a_i = 1'b0; b_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_hist = 4'd0; m_pos = '0;
    @(negedge clk);
    chk("R9 hist", 32'(hist_o), 32'd0);
    chk("R9 pos", 32'(pos_o), 32'd0);
    chk("R9 dir", 32'(dir_o), 32'd1);
    move(1, 0);
    chk("R9 resume", 32'(pos_o), 32'd1);
    repeat (4) @(negedge clk);
    chk("R6 queue drained", 32'(q.size()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule